// File: doc/BRIEF.md
# Integer Execution Unit

This block is the integer execution stage of a small load-store core. It is purely combinational: in the same cycle it turns two register operands, a shift count, a 16-bit instruction constant and a four-bit operation code into a 32-bit result and a flag that is high when that result is all zeros. The branch unit uses the flag to test equality, by issuing a subtract and looking at the flag.

The unit has one adder/subtractor, one logic unit and one log-stage barrel shifter. Every operation reads at most two sources and produces one result. Signed and unsigned "less than" come from the same subtract. Constant-operand forms take the 16-bit constant in place of the second register. The constant is sign-extended for the arithmetic and compare forms and zero-extended for the logic forms. An upper-constant operation places the constant in the top half of the word, so that it and a following OR-with-constant can build any 32-bit value in two steps.

Top module: `int_exec_unit`

## Requirements
- R1: Op code 0 returns src_a + src_b, and op code 10 returns src_a plus the sign-extended imm. Both wrap modulo 2^32 with no trap.
- R2: Op code 1 returns src_a - src_b, wrapping modulo 2^32. With equal operands the result is 0.
- R3: Op codes 2, 3 and 4 return src_a AND src_b, src_a OR src_b and NOT(src_a OR src_b) respectively. Code 4 with src_b = 0 yields the bitwise inverse of src_a.
- R4: Op codes 11 and 12 return src_a AND, and src_a OR, the zero-extended imm. Bits 31..16 of the constant are always 0.
- R5: Op code 5 returns 1 when src_a < src_b as signed two's complement values, and 0 otherwise. Op code 6 makes the same comparison unsigned. Bits 31..1 of the result are 0.
- R6: Op code 13 compares src_a with the sign-extended imm as signed values. Op code 14 compares them as unsigned values. Both return 1 or 0.
- R7: Op code 7 returns src_b shifted left by shamt, and op code 8 returns src_b shifted right by shamt. Vacated bits are filled with 0, and src_a has no effect on either.
- R8: Op code 9 returns imm in bits 31..16 and 0 in bits 15..0, and ignores src_a and src_b.
- R9: A code-9 result fed back as src_a to op code 12 produces the 32-bit constant {imm_first, imm_second}.
- R10: The zero output is 1 exactly when the result equals 0, for every op code.
- R11: The unused op code 15 returns 0, so the zero output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (values listed in the requirements) |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand; this is the value that is shifted |
| shamt | input | 5 | Constant shift count |
| imm | input | 16 | Instruction constant |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
Two results can coincide in one evaluation. An add or subtract can wrap past 2^32 and, in the same evaluation, produce exactly zero, which raises the zero flag. This is forced with directed operands: all-ones plus one, an operand minus itself, and the 0x80000000 / 0x7FFFFFFF boundaries. Random corner-weighted operands provoke it further. Each evaluation is judged against a behavioural model that predicts the result and the flag separately. The signed and unsigned compares are also driven with the same operand pair, so that their opposite answers on sign-boundary values are compared in the same step.

// File: rtl/iexu_pkg.sv
package iexu_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_NOR   = 4'd4,
    OP_SLT   = 4'd5,
    OP_SLTU  = 4'd6,
    OP_SLL   = 4'd7,
    OP_SRL   = 4'd8,
    OP_LUI   = 4'd9,
    OP_ADDI  = 4'd10,
    OP_ANDI  = 4'd11,
    OP_ORI   = 4'd12,
    OP_SLTI  = 4'd13,
    OP_SLTIU = 4'd14,
    OP_SPARE = 4'd15
  } iexu_op_e;

  typedef enum logic [1:0] {
    LF_AND = 2'd0,
    LF_OR  = 2'd1,
    LF_NOR = 2'd2
  } iexu_lfn_e;
endpackage

// File: rtl/iexu_imm_ext.sv
module iexu_imm_ext #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic              sign_en,
  output logic [DATA_W-1:0] ext,
  output logic [DATA_W-1:0] upper
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic fill;
  assign fill  = sign_en & imm[IMM_W-1];
  assign ext   = {{PAD_W{fill}}, imm};
  assign upper = {imm, {PAD_W{1'b0}}};
endmodule

// File: rtl/iexu_addsub.sv
module iexu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub_en,
  output logic [DATA_W-1:0] sum,
  output logic              lt_s,
  output logic              lt_u
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  assign b_eff = sub_en ? ~b : b;
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_en};
  assign sum   = wide[MSB:0];
  // carry out of a + ~b + 1 is the "no borrow" indication
  assign lt_u  = ~wide[DATA_W];
  assign lt_s  = (a[MSB] ^ b[MSB]) ? a[MSB] : wide[MSB];
endmodule

// File: rtl/iexu_shift.sv
module iexu_shift #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = 5
) (
  input  logic [DATA_W-1:0]  din,
  input  logic [SHAMT_W-1:0] amt,
  input  logic               left,
  output logic [DATA_W-1:0]  dout
);
  logic [DATA_W-1:0] din_rev;
  logic [DATA_W-1:0] last_rev;
  logic [DATA_W-1:0] stage [0:SHAMT_W];

  // right shifts reuse the left-shift stages on a bit-reversed word
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign din_rev[i]  = din[DATA_W-1-i];
    assign last_rev[i] = stage[SHAMT_W][DATA_W-1-i];
  end

  assign stage[0] = left ? din : din_rev;

  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt[k] ? (stage[k] << STEP) : stage[k];
  end

  assign dout = left ? stage[SHAMT_W] : last_rev;
endmodule

// File: rtl/iexu_logic.sv
module iexu_logic
  import iexu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  iexu_lfn_e         fn,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (fn)
      LF_AND:  y = a & b;
      LF_OR:   y = a | b;
      LF_NOR:  y = ~(a | b);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iexu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [3:0]         op_sel,
  input  logic [DATA_W-1:0]  src_a,
  input  logic [DATA_W-1:0]  src_b,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [IMM_W-1:0]   imm,
  output logic [DATA_W-1:0]  result,
  output logic               zero
);
  localparam logic [DATA_W-1:0] ONE_W = {{(DATA_W-1){1'b0}}, 1'b1};

  iexu_op_e  op;
  logic      use_imm;
  logic      imm_sign;
  logic      sub_en;
  logic      shl;
  iexu_lfn_e lfn;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] imm_upper;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] sum;
  logic              lt_s;
  logic              lt_u;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] logic_y;

  assign op = iexu_op_e'(op_sel);

  // operation decode
  always_comb begin
    use_imm  = 1'b0;
    imm_sign = 1'b0;
    sub_en   = 1'b0;
    shl      = 1'b1;
    lfn      = LF_AND;
    case (op)
      OP_SUB, OP_SLT, OP_SLTU: sub_en = 1'b1;
      OP_OR:                   lfn = LF_OR;
      OP_NOR:                  lfn = LF_NOR;
      OP_SRL:                  shl = 1'b0;
      OP_ADDI: begin
        use_imm  = 1'b1;
        imm_sign = 1'b1;
      end
      OP_ANDI:                 use_imm = 1'b1;
      OP_ORI: begin
        use_imm = 1'b1;
        lfn     = LF_OR;
      end
      OP_SLTI, OP_SLTIU: begin
        use_imm  = 1'b1;
        imm_sign = 1'b1;
        sub_en   = 1'b1;
      end
      default: ;
    endcase
  end

  iexu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
    .imm     (imm),
    .sign_en (imm_sign),
    .ext     (imm_ext),
    .upper   (imm_upper)
  );

  assign opnd_b = use_imm ? imm_ext : src_b;

  iexu_addsub #(.DATA_W(DATA_W)) u_add (
    .a      (src_a),
    .b      (opnd_b),
    .sub_en (sub_en),
    .sum    (sum),
    .lt_s   (lt_s),
    .lt_u   (lt_u)
  );

  iexu_logic #(.DATA_W(DATA_W)) u_log (
    .a  (src_a),
    .b  (opnd_b),
    .fn (lfn),
    .y  (logic_y)
  );

  iexu_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shf (
    .din  (src_b),
    .amt  (shamt),
    .left (shl),
    .dout (shifted)
  );

  // result select
  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_ADDI:                  result = sum;
      OP_AND, OP_OR, OP_NOR, OP_ANDI, OP_ORI:   result = logic_y;
      OP_SLT, OP_SLTI:                          result = lt_s ? ONE_W : '0;
      OP_SLTU, OP_SLTIU:                        result = lt_u ? ONE_W : '0;
      OP_SLL, OP_SRL:                           result = shifted;
      OP_LUI:                                   result = imm_upper;
      default:                                  result = '0;
    endcase
  end

  assign zero = ~|result;
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input logic [3:0]         op_sel,
  input logic [DATA_W-1:0]  src_a,
  input logic [DATA_W-1:0]  src_b,
  input logic [SHAMT_W-1:0] shamt,
  input logic [IMM_W-1:0]   imm,
  input logic [DATA_W-1:0]  result,
  input logic               zero
);
  localparam int LOW_W = DATA_W - IMM_W;
  localparam logic [DATA_W-1:0] ONES = '1;

  logic known;
  assign known = !$isunknown({op_sel, src_a, src_b, shamt, imm});

  always_comb begin
    if (known) begin
      // R10: flag tracks the result word
      a_r10_zero_flag: assert (zero == (result == '0))
        else $error("zero flag disagrees with result");
      // R8: upper-constant clears the low half and carries imm on top
      if (op_sel == 4'd9) begin
        a_r8_lui_halves: assert (result[LOW_W-1:0] == '0 && result[DATA_W-1:LOW_W] == imm)
          else $error("upper-constant layout wrong");
      end
      // R5 / R6: compares yield a 0/1 word
      if (op_sel == 4'd5 || op_sel == 4'd6 || op_sel == 4'd13 || op_sel == 4'd14) begin
        a_r5_compare_bool: assert (result[DATA_W-1:1] == '0)
          else $error("compare result not boolean");
      end
      // R7: vacated positions are zero
      if (op_sel == 4'd7) begin
        a_r7_sll_fill: assert ((result & ~(ONES << shamt)) == '0)
          else $error("left shift fill not zero");
      end
      if (op_sel == 4'd8) begin
        a_r7_srl_fill: assert ((result & ~(ONES >> shamt)) == '0)
          else $error("right shift fill not zero");
      end
      // R11: spare code gives zero
      if (op_sel == 4'd15) begin
        a_r11_spare_zero: assert (result == '0 && zero)
          else $error("spare code not zero");
      end
    end
  end
endmodule

bind int_exec_unit int_exec_unit_chk #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W)
) u_chk (
  .op_sel (op_sel),
  .src_a  (src_a),
  .src_b  (src_b),
  .shamt  (shamt),
  .imm    (imm),
  .result (result),
  .zero   (zero)
);

// File: tb/sim_int_exec_unit.sv
module sim_int_exec_unit;
  logic        clk;
  logic        rst_n;
  logic [3:0]  op_sel;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic [4:0]  shamt;
  logic [15:0] imm;
  logic [31:0] result;
  logic        zero;

  int checks;
  int failures;

  int_exec_unit u0 (
    .op_sel (op_sel),
    .src_a  (src_a),
    .src_b  (src_b),
    .shamt  (shamt),
    .imm    (imm),
    .result (result),
    .zero   (zero)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural reference
  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [4:0] sh,
                                        input logic [15:0] im);
    logic [31:0] sx;
    logic [31:0] zx;
    sx = {{16{im[15]}}, im};
    zx = {16'h0000, im};
    case (op)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return a & b;
      4'd3:  return a | b;
      4'd4:  return ~(a | b);
      4'd5:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd6:  return (a < b) ? 32'd1 : 32'd0;
      4'd7:  return b << sh;
      4'd8:  return b >> sh;
      4'd9:  return {im, 16'h0000};
      4'd10: return a + sx;
      4'd11: return a & zx;
      4'd12: return a | zx;
      4'd13: return ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
      4'd14: return (a < sx) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd10:        return "R1";
      4'd1:               return "R2";
      4'd2, 4'd3, 4'd4:   return "R3";
      4'd11, 4'd12:       return "R4";
      4'd5, 4'd6:         return "R5";
      4'd13, 4'd14:       return "R6";
      4'd7, 4'd8:         return "R7";
      4'd9:               return "R8";
      default:            return "R11";
    endcase
  endfunction

  task automatic run(input string tag, input logic [3:0] op, input logic [31:0] a,
                     input logic [31:0] b, input logic [4:0] sh, input logic [15:0] im,
                     output logic [31:0] got);
    logic [31:0] exp;
    @(posedge clk);
    op_sel = op; src_a = a; src_b = b; shamt = sh; imm = im;
    exp = model(op, a, b, sh, im);
    @(negedge clk);
    got = result;
    checks++;
    if (result !== exp) begin
      failures++;
      $display("FAIL %s op=%0d result actual=%08h expected=%08h", tag, op, result, exp);
    end
    checks++;
    if (zero !== (exp == 32'd0)) begin
      failures++;
      $display("FAIL R10 (%s) op=%0d zero actual=%0b expected=%0b", tag, op, zero, exp == 32'd0);
    end
  endtask

  task automatic expect_eq(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] corner(input int unsigned sel);
    case (sel % 7)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      4: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] r0;
    logic [31:0] r1;
    checks = 0; failures = 0;
    rst_n = 1'b0;
    op_sel = 4'd0; src_a = '0; src_b = '0; shamt = '0; imm = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 idle state with all-zero inputs
    expect_eq("R10 idle result", result, 32'd0);
    expect_eq("R10 idle zero", {31'd0, zero}, 32'd1);
    rst_n = 1'b1;

    // R1 wrap to zero coincides with zero flag (R10)
    run("R1 wrap", 4'd0, 32'hFFFF_FFFF, 32'd1, 5'd0, 16'h0, r0);
    expect_eq("R1 wrap value", r0, 32'd0);
    run("R1 addi sign", 4'd10, 32'd0, 32'h1234_5678, 5'd0, 16'hFFFF, r0);
    expect_eq("R1 addi -1", r0, 32'hFFFF_FFFF);
    // R2 equal operands
    run("R2 equal", 4'd1, 32'h8000_0000, 32'h8000_0000, 5'd0, 16'h0, r0);
    expect_eq("R2 equal zero", r0, 32'd0);
    run("R2 wrap", 4'd1, 32'd0, 32'd1, 5'd0, 16'h0, r0);
    expect_eq("R2 wrap value", r0, 32'hFFFF_FFFF);
    // R3 NOR with zero operand inverts
    run("R3 nor-not", 4'd4, 32'hA5A5_0F0F, 32'd0, 5'd0, 16'h0, r0);
    expect_eq("R3 not value", r0, 32'h5A5A_F0F0);
    // R4 zero extension
    run("R4 andi", 4'd11, 32'hFFFF_FFFF, 32'd0, 5'd0, 16'h8000, r0);
    expect_eq("R4 andi zext", r0, 32'h0000_8000);
    run("R4 ori", 4'd12, 32'd0, 32'hFFFF_FFFF, 5'd0, 16'hFFFF, r0);
    expect_eq("R4 ori zext", r0, 32'h0000_FFFF);
    // R5 signed vs unsigned at the sign boundary
    run("R5 slt", 4'd5, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 16'h0, r0);
    run("R5 sltu", 4'd6, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 16'h0, r1);
    expect_eq("R5 slt boundary", r0, 32'd1);
    expect_eq("R5 sltu boundary", r1, 32'd0);
    // R6 immediate compares
    run("R6 slti", 4'd13, 32'hFFFF_FFFE, 32'd0, 5'd0, 16'hFFFF, r0);
    expect_eq("R6 slti -2<-1", r0, 32'd1);
    run("R6 sltiu", 4'd14, 32'd5, 32'd0, 5'd0, 16'hFFFF, r0);
    expect_eq("R6 sltiu 5<max", r0, 32'd1);
    // R7 shifts ignore src_a
    run("R7 sll", 4'd7, 32'h0000_0000, 32'd1, 5'd31, 16'h0, r0);
    run("R7 sll a-ignored", 4'd7, 32'hDEAD_BEEF, 32'd1, 5'd31, 16'h0, r1);
    expect_eq("R7 sll value", r0, 32'h8000_0000);
    expect_eq("R7 src_a ignored", r1, r0);
    run("R7 srl", 4'd8, 32'h1234_5678, 32'h8000_0000, 5'd31, 16'h0, r0);
    expect_eq("R7 srl value", r0, 32'd1);
    // R8 upper constant ignores registers
    run("R8 lui", 4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3, 16'h003D, r0);
    expect_eq("R8 lui value", r0, 32'h003D_0000);
    // R9 two-step constant build
    run("R9 ori after lui", 4'd12, r0, 32'd0, 5'd0, 16'h0900, r1);
    expect_eq("R9 built constant", r1, 32'h003D_0900);
    // R11 spare code
    run("R11 spare", 4'd15, 32'hFFFF_FFFF, 32'h1, 5'd1, 16'h1, r0);
    expect_eq("R11 spare value", r0, 32'd0);

    // corner-weighted sweep over every code
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] op;
      op = 4'(n % 16);
      run(tag_of(op), op, corner($urandom), corner($urandom), 5'($urandom),
          16'($urandom), r0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule